// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus initiator and a single bus target through a return-to-zero handshake. Each side runs on its own clock. The initiator side takes a one-cycle `start` command carrying direction, address and write data. It puts address, direction and (for writes) data on a shared bus, then waits a fixed decode-settling interval. Only after that interval does it raise the request line. The target side resynchronises request, decodes the upper address bits against a base value and answers with acknowledge:

- For a write, the target stores the word before it acknowledges.
- For a read, the target drives the stored word before it acknowledges.

The initiator resynchronises acknowledge. For a read it captures the data, then drops request. The target drops acknowledge and releases its data drivers once it sees request low. The initiator reports completion only after it has seen acknowledge low, so the next address cannot appear too early.

If no target answers, a timeout ends the transfer and flags an error.

Initiator states:
- `M_IDLE`: waits for `start`.
- `M_SETTLE`: counts the decode interval, then goes to `M_REQ`.
- `M_REQ`: holds request high until acknowledge arrives or the timeout expires, then goes to `M_RELEASE`.
- `M_RELEASE`: holds request low until acknowledge is low, then goes back to `M_IDLE` and pulses `done`.

Target states:
- `S_IDLE`: on a synchronised request with an address hit, stores or drives data, raises acknowledge and goes to `S_ACK`.
- `S_ACK`: on synchronised request low, drops acknowledge and the data enable and goes back to `S_IDLE`.

Top module: `hs4_top`

## Requirements
- R1: `busy` goes high on the initiator clock edge that accepts `start` and stays high until the edge that raises `done`. On that edge `busy` returns low and `done` is high for exactly one cycle.
- R2: Request (`req_mon`) rises on the DECODE_DLY-th initiator clock edge after the edge that accepts `start`. With the default DECODE_DLY = 2, that is the second edge.
- R3: A write to an address whose upper AW-IDX_W bits equal BASE stores `wdata` in word `addr[IDX_W-1:0]`. With the defaults, BASE = 6'h0A, so addresses 0x28 to 0x2B hit.
- R4: A read of a hitting address returns the stored word on `rdata` while `done` is high. Words never written read as zero after reset. The two sides never drive the shared data lines at once.
- R5: Acknowledge (`ack_mon`) falls only after request has fallen. `done` is raised only once acknowledge is low. Request never rises while acknowledge is high.
- R6: If no target acknowledges, request stays high for exactly TIMEOUT_CYC initiator cycles (default 64) and then falls. The transfer then ends with `err` high together with `done`.
- R7: A transfer that is acknowledged ends with `err` low.
- R8: After reset, `busy`, `done`, `err`, `req_mon` and `ack_mon` are all low.
- R9: A `start` given while `busy` is high is ignored: it produces no transfer, no `done` and no change to stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Initiator clock |
| mrst_n | input | 1 | Initiator active-low reset |
| sclk | input | 1 | Target clock |
| srst_n | input | 1 | Target active-low reset |
| start | input | 1 | One-cycle command strobe (initiator clock) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Transfer address |
| wdata | input | DW | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rdata | output | DW | Read data, valid with `done` |
| req_mon | output | 1 | Request line of the link |
| ack_mon | output | 1 | Acknowledge line of the link |

## Verification
The bound checker watches the ordering of the handshake on every cycle:
- request rises only while acknowledge is low;
- acknowledge rises only while request is high and falls only after request is low;
- address and direction hold while request is high;
- the two data drivers never overlap;
- `err` appears only with `done`.

Other behaviours show only in the bench's scenarios: the exact settling delay, the exact timeout length, the stored and returned data values, the reset contents, and a `start` that arrives mid-transfer being dropped.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETTLE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } mst_state_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_t;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q      <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hs4_master.sv
module hs4_master
    import hs4_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int DECODE_DLY  = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    output logic          req,
    input  logic          ack_in,
    input  logic [DW-1:0] bus_data
);
    localparam int SW = (DECODE_DLY > 1) ? $clog2(DECODE_DLY) : 1;
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(DECODE_DLY - 1);
    localparam logic [TW-1:0] WAIT_LAST   = TW'(TIMEOUT_CYC - 1);

    mst_state_t    state, state_nx;
    logic          ack_s;
    logic [SW-1:0] settle_cnt;
    logic [TW-1:0] wait_cnt;
    logic          timed_out;

    hs4_sync u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            M_IDLE:    if (start) state_nx = M_SETTLE;
            M_SETTLE:  if (settle_cnt == SETTLE_LAST) state_nx = M_REQ;
            M_REQ:     if (ack_s || (wait_cnt == WAIT_LAST)) state_nx = M_RELEASE;
            M_RELEASE: if (!ack_s) state_nx = M_IDLE;
            default:   state_nx = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr   <= '0;
            bus_write  <= 1'b0;
            bus_wdata  <= '0;
            req        <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            rdata      <= '0;
            settle_cnt <= '0;
            wait_cnt   <= '0;
            timed_out  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (start) begin
                        bus_addr   <= addr;
                        bus_write  <= wr;
                        bus_wdata  <= wdata;
                        settle_cnt <= '0;
                        timed_out  <= 1'b0;
                    end
                end
                M_SETTLE: begin
                    settle_cnt <= settle_cnt + 1'b1;
                    if (settle_cnt == SETTLE_LAST) begin
                        req      <= 1'b1;
                        wait_cnt <= '0;
                    end
                end
                M_REQ: begin
                    wait_cnt <= wait_cnt + 1'b1;
                    if (ack_s) begin
                        if (!bus_write) rdata <= bus_data;
                        req <= 1'b0;
                    end else if (wait_cnt == WAIT_LAST) begin
                        req       <= 1'b0;
                        timed_out <= 1'b1;
                    end
                end
                M_RELEASE: begin
                    if (!ack_s) begin
                        done <= 1'b1;
                        err  <= timed_out;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy         = (state != M_IDLE);
    assign bus_wdata_oe = busy && bus_write;
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int              AW    = 8,
    parameter int              DW    = 16,
    parameter int              IDX_W = 2,
    parameter logic [AW-IDX_W-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_write,
    input  logic [DW-1:0] bus_data,
    output logic          ack,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    localparam int NWORDS = 1 << IDX_W;

    slv_state_t       state, state_nx;
    logic             req_s;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    mem [NWORDS];

    hs4_sync u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s));

    assign hit = (bus_addr[AW-1:IDX_W] == BASE);
    assign idx = bus_addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_s && hit) state_nx = S_ACK;
            S_ACK:   if (!req_s) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack     <= 1'b0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_s && hit) begin
                        ack <= 1'b1;
                        if (!bus_write) begin
                            dout    <= mem[idx];
                            dout_oe <= 1'b1;
                        end
                    end
                end
                S_ACK: begin
                    if (!req_s) begin
                        ack     <= 1'b0;
                        dout_oe <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (state == S_IDLE && req_s && hit && bus_write
                         && idx == IDX_W'(g)) begin
                mem[g] <= bus_data;
            end
        end
    end
endmodule

// File: rtl/hs4_top.sv
module hs4_top #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int IDX_W       = 2,
    parameter int DECODE_DLY  = 2,
    parameter int TIMEOUT_CYC = 64,
    parameter logic [AW-IDX_W-1:0] BASE = 6'h0A
) (
    input  logic          mclk,
    input  logic          mrst_n,
    input  logic          sclk,
    input  logic          srst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          req_mon,
    output logic          ack_mon
);
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [DW-1:0] m_wdata;
    logic          m_oe;
    logic          m_req;
    logic          s_ack;
    logic [DW-1:0] s_dout;
    logic          s_oe;
    logic [DW-1:0] data_bus;

    assign data_bus = s_oe ? s_dout : (m_oe ? m_wdata : '0);

    hs4_master #(
        .AW(AW), .DW(DW), .DECODE_DLY(DECODE_DLY), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_mst (
        .clk(mclk), .rst_n(mrst_n),
        .start(start), .wr(wr), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_wdata(m_wdata), .bus_wdata_oe(m_oe),
        .req(m_req), .ack_in(s_ack), .bus_data(data_bus)
    );

    hs4_slave #(
        .AW(AW), .DW(DW), .IDX_W(IDX_W), .BASE(BASE)
    ) u_slv (
        .clk(sclk), .rst_n(srst_n),
        .req_in(m_req), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_data(data_bus),
        .ack(s_ack), .dout(s_dout), .dout_oe(s_oe)
    );

    assign req_mon = m_req;
    assign ack_mon = s_ack;
endmodule

// File: rtl/hs4_chk.sv
module hs4_chk #(
    parameter int AW = 8
) (
    input logic          mclk,
    input logic          mrst_n,
    input logic          sclk,
    input logic          srst_n,
    input logic          m_req,
    input logic          s_ack,
    input logic          m_oe,
    input logic          s_oe,
    input logic [AW-1:0] bus_addr,
    input logic          bus_write,
    input logic          done,
    input logic          err
);
    p_addr_hold_r1: assert property (@(posedge mclk) disable iff (!mrst_n)
        (m_req && $past(m_req)) |-> ($stable(bus_addr) && $stable(bus_write)));

    p_req_rise_r5: assert property (@(posedge mclk) disable iff (!mrst_n)
        $rose(m_req) |-> !s_ack);

    p_done_ack_low_r5: assert property (@(posedge mclk) disable iff (!mrst_n)
        done |-> !s_ack);

    p_ack_rise_r3: assert property (@(posedge sclk) disable iff (!srst_n)
        $rose(s_ack) |-> m_req);

    p_ack_fall_r5: assert property (@(posedge sclk) disable iff (!srst_n)
        $fell(s_ack) |-> !m_req);

    p_err_with_done_r6: assert property (@(posedge mclk) disable iff (!mrst_n)
        err |-> done);

    always @(posedge mclk) begin
        if (mrst_n && srst_n) begin
            p_no_contention_r4: assert (!(m_oe && s_oe));
        end
    end
endmodule

bind hs4_top hs4_chk #(.AW(AW)) u_chk (
    .mclk(mclk), .mrst_n(mrst_n), .sclk(sclk), .srst_n(srst_n),
    .m_req(m_req), .s_ack(s_ack), .m_oe(m_oe), .s_oe(s_oe),
    .bus_addr(bus_addr), .bus_write(bus_write),
    .done(done), .err(err)
);

// File: tb/sim_hs4_top.sv
module sim_hs4_top;
    localparam int DLY = 2;
    localparam int TOC = 64;

    typedef struct packed {
        logic        rd;
        logic        err;
        logic [15:0] data;
    } exp_t;

    logic        mclk = 0, sclk = 0, mrst_n = 0, srst_n = 0;
    logic        start = 0, wr = 0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, err, req_mon, ack_mon;
    logic [15:0] rdata;

    int   checks = 0, fails = 0, dones = 0;
    exp_t sbq[$];
    logic [15:0] model [4];

    always #2.5 mclk = ~mclk;
    always #3.5 sclk = ~sclk;

    hs4_top u0 (
        .mclk(mclk), .mrst_n(mrst_n), .sclk(sclk), .srst_n(srst_n),
        .start(start), .wr(wr), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .req_mon(req_mon), .ack_mon(ack_mon)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: pops expectations as done pulses appear
    always @(negedge mclk) begin
        if (mrst_n && done) begin
            exp_t e;
            dones++;
            chk(busy == 1'b0, "R1 busy low with done", busy, 0);
            chk(ack_mon == 1'b0, "R5 ack low at done", ack_mon, 0);
            if (sbq.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                e = sbq.pop_front();
                if (e.err) chk(err == 1'b1, "R6 err on timeout", err, 1);
                else       chk(err == 1'b0, "R7 err low on ack", err, 0);
                if (e.rd && !e.err) chk(rdata == e.data, "R4 read data", rdata, e.data);
            end
        end
    end

    task automatic xfer(input bit w, input logic [7:0] a, input logic [15:0] d,
                        input bit exp_err, input bit junk);
        exp_t e;
        int   n;
        while (busy) @(negedge mclk);
        e.rd   = !w;
        e.err  = exp_err;
        e.data = model[a[1:0]];
        sbq.push_back(e);
        if (w && !exp_err) model[a[1:0]] = d;
        start = 1; wr = w; addr = a; wdata = d;
        @(negedge mclk);
        start = 0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        if (junk) begin
            start = 1; wr = 1; addr = 8'h2A; wdata = 16'hFFFF;
            @(negedge mclk);
            start = 0;
            n = 2;
        end else begin
            n = 1;
        end
        while (!req_mon) begin
            @(negedge mclk);
            n++;
        end
        chk(n == DLY + 1, "R2 settle delay", n, DLY + 1);
        if (exp_err) begin
            n = 0;
            while (req_mon) begin
                chk(ack_mon == 1'b0, "R6 no ack", ack_mon, 0);
                @(negedge mclk);
                n++;
            end
            chk(n == TOC, "R6 request length", n, TOC);
        end
        while (busy) @(negedge mclk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge mclk);
        chk(busy == 0 && done == 0 && err == 0, "R8 reset outputs", {busy, done, err}, 0);
        chk(req_mon == 0 && ack_mon == 0, "R8 reset handshake", {req_mon, ack_mon}, 0);
        mrst_n = 1; srst_n = 1;
        repeat (2) @(negedge mclk);
        chk(busy == 0 && req_mon == 0, "R8 idle after reset", {busy, req_mon}, 0);

        xfer(0, 8'h29, 16'h0, 0, 0);            // R4 unwritten word reads zero
        xfer(1, 8'h28, 16'hA5A5, 0, 0);         // R3
        xfer(1, 8'h2B, 16'h1234, 0, 0);         // R3
        xfer(0, 8'h28, 16'h0, 0, 0);            // R4
        xfer(0, 8'h2B, 16'h0, 0, 0);            // R4
        xfer(1, 8'h29, 16'h5A5A, 0, 1);         // R9 start while busy
        xfer(0, 8'h2A, 16'h0, 0, 0);            // R9 word 2 untouched
        xfer(0, 8'h29, 16'h0, 0, 0);            // R3
        xfer(1, 8'h10, 16'hDEAD, 1, 0);         // R6 no target
        xfer(0, 8'h28, 16'h0, 0, 0);            // R7 recovery
        xfer(1, 8'h28, 16'h0F0F, 0, 0);         // R3 overwrite
        xfer(0, 8'h28, 16'h0, 0, 0);            // R4

        repeat (10) @(negedge mclk);
        chk(sbq.size() == 0, "R9 all expected done", sbq.size(), 0);
        chk(dones == 12, "R9 done count", dones, 12);
        summary();
    end

    initial begin
        repeat (100000) @(posedge mclk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule